// File: doc/BRIEF.md
# Register-Mapped Serial Port Controller

This block is a serial port controller that a processor drives through a small 32-bit register window. Words written to the data register go into an eight-entry transmit queue. While the port is enabled, a transfer engine takes them out in order. Each word is either shifted out on a four-wire serial bus as the bus master, with the word clocked back in returned to the receive queue, or, in loopback mode, copied straight into the receive queue. Reading the data register returns the oldest received word.

The frame width is programmable from 1 to 16 bits. Each word is cut to that width when it enters either queue. The engine never lets the receive queue overflow: it holds back transmission until software has made room. Two threshold interrupts drive a single request line through a mask register. One fires when the receive queue is at least half full, the other when the transmit queue is at most half full. A prescale value can be stored and read back, but the serial clock always comes from a fixed divider set by a parameter.

Top module: `ssp_ctrl`

## Requirements
- R1: After reset, status (0x0C) reads 0x03, raw interrupt status (0x18) reads 0x08, mask (0x14) and masked status (0x1C) read 0, `irq` is low, `spi_csn` is high and `spi_sclk` is low.
- R2: The frame width is control0 (0x00) bits [3:0] plus 1. A word written to data (0x08) is cut to that width on entry to the transmit queue, and cut again with the width in force when it is stored into the receive queue.
- R3: Each queue holds 8 words and keeps first-in first-out order. A data write while the transmit queue holds 8 words is discarded.
- R4: A data read with an empty receive queue returns 0 and changes nothing. Otherwise it returns the oldest word and removes it.
- R5: Status bit 0 means transmit queue empty, bit 1 transmit queue not full, bit 2 receive queue not empty, bit 3 receive queue full, and bit 4 busy. Busy is set while the transmit queue holds a word or a serial frame is in progress.
- R6: Words move only while control1 (0x04) bit 1 is set. With control1 bit 0 also set (loopback), one word per clock moves from the transmit queue to the receive queue.
- R7: While the receive queue is full, no word leaves the transmit queue. Once space is made, the held words follow in order and none is lost.
- R8: Raw interrupt bit 2 is set when the receive queue holds 4 or more words, and bit 3 when the transmit queue holds 4 or fewer. Masked status is raw AND mask, and `irq` is high when any masked bit is set.
- R9: Without loopback, each word is sent as one serial frame in mode 0. `spi_csn` is low for the whole frame. The most significant bit of the programmed width goes first. `spi_mosi` changes only while `spi_sclk` is low, `spi_miso` is sampled on the rising edge, and `spi_sclk` has a period of 2*SCLK_HALF clocks. The word shifted in is stored in the receive queue.
- R10: Control0 (16 bits), control1 (4 bits), mask (4 bits) and prescale (0x10, low 8 bits kept) read back what was written.
- R11: Reads of word offsets 0xFE0 through 0xFFC return the identification bytes 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in that order.
- R12: Offset 0x20 and unmapped offsets read 0. Writes to them, and to status, raw status and masked status, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 12 | Byte offset of the access (word aligned) |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe; a data read pops at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle `bus_rd` is high |
| irq | output | 1 | Interrupt request |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_csn | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high together, and that the addresses are word aligned. The bench drives each access alone, holds it for exactly one clock, and always uses aligned offsets. The serial checks assume `spi_miso` is settled before each rising serial clock. The bench's slave model changes it only when chip select falls or the serial clock falls.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    localparam logic [11:0] OFF_CTRL0  = 12'h000;
    localparam logic [11:0] OFF_CTRL1  = 12'h004;
    localparam logic [11:0] OFF_DATA   = 12'h008;
    localparam logic [11:0] OFF_STAT   = 12'h00C;
    localparam logic [11:0] OFF_PRESC  = 12'h010;
    localparam logic [11:0] OFF_MASK   = 12'h014;
    localparam logic [11:0] OFF_RAW    = 12'h018;
    localparam logic [11:0] OFF_MASKED = 12'h01C;
    localparam logic [6:0]  ID_PAGE    = 7'h7F;

    localparam int C1_LOOP = 0;
    localparam int C1_EN   = 1;

    typedef struct packed {
        logic [15:0] ctrl0;
        logic [3:0]  ctrl1;
        logic [7:0]  presc;
        logic [3:0]  mask;
    } regs_t;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0: id_byte = 8'h22;
            3'd1: id_byte = 8'h10;
            3'd2: id_byte = 8'h04;
            3'd3: id_byte = 8'h00;
            3'd4: id_byte = 8'h0D;
            3'd5: id_byte = 8'hF0;
            3'd6: id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [WIDTH-1:0]             din,
    input  logic                         pop,
    output logic [WIDTH-1:0]             dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            head;
        logic [CNT_W-1:0]            count;
    } fifo_t;

    fifo_t st_d, st_q;
    logic [PTR_W-1:0] tail;

    assign tail  = st_q.head - PTR_W'(st_q.count);
    assign dout  = st_q.mem[tail];
    assign count = st_q.count;
    assign full  = (st_q.count == CNT_W'(DEPTH));
    assign empty = (st_q.count == '0);

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.head] = din;
            st_d.head = st_q.head + 1'b1;
        end
        st_d.count = st_q.count + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));
    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.count == $past(st_q.count) ||
                  st_q.count == $past(st_q.count) + 1'b1 ||
                  st_q.count + 1'b1 == $past(st_q.count)));
endmodule

// File: rtl/ssp_spi_shifter.sv
module ssp_spi_shifter #(
    parameter int DATA_W = 16,
    parameter int HALF   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [$clog2(DATA_W+1)-1:0] width,
    input  logic [DATA_W-1:0]           word,
    input  logic                        miso,
    output logic                        busy,
    output logic                        done,
    output logic [DATA_W-1:0]           rx_word,
    output logic                        sclk,
    output logic                        csn,
    output logic                        mosi
);
    localparam int BITS_W = $clog2(DATA_W+1);
    localparam int DIV_W  = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              sclk;
        logic              csn;
        logic [DIV_W-1:0]  div;
        logic [BITS_W-1:0] left;
        logic [DATA_W-1:0] tx_sh;
        logic [DATA_W-1:0] rx_sh;
    } sh_t;

    sh_t st_d, st_q;

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign rx_word = st_q.rx_sh;
    assign sclk    = st_q.sclk;
    assign csn     = st_q.csn;
    assign mosi    = st_q.busy & st_q.tx_sh[DATA_W-1];

    always_comb begin
        st_d = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy  = 1'b1;
                st_d.csn   = 1'b0;
                st_d.sclk  = 1'b0;
                st_d.div   = '0;
                st_d.left  = width;
                st_d.tx_sh = word << (DATA_W - int'(width));
                st_d.rx_sh = '0;
            end
        end else if (st_q.div == DIV_W'(HALF-1)) begin
            st_d.div = '0;
            if (!st_q.sclk) begin
                st_d.sclk  = 1'b1;
                st_d.rx_sh = {st_q.rx_sh[DATA_W-2:0], miso};
            end else begin
                st_d.sclk  = 1'b0;
                st_d.tx_sh = st_q.tx_sh << 1;
                st_d.left  = st_q.left - 1'b1;
                if (st_q.left == BITS_W'(1)) begin
                    st_d.busy = 1'b0;
                    st_d.csn  = 1'b1;
                    st_d.done = 1'b1;
                end
            end
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.csn <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R9
    sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.sclk) |-> !st_q.csn);
    // R9
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sclk && $past(st_q.sclk)) |-> $stable(mosi));
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (st_q.csn && !st_q.sclk));
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
    import ssp_pkg::*;
#(
    parameter int SCLK_HALF = 2,
    parameter int FIFO_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [11:0] bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        spi_sclk,
    output logic        spi_csn,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int DATA_W = 16;
    localparam int CNT_W  = $clog2(FIFO_DEPTH+1);
    localparam int BITS_W = $clog2(DATA_W+1);
    localparam int THRESH = FIFO_DEPTH / 2;

    regs_t regs_d, regs_q;

    logic [DATA_W-1:0] tx_dout, rx_dout, rx_din, sh_rx, fmask;
    logic [CNT_W-1:0]  tx_cnt, rx_cnt;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic tx_push, tx_pop, rx_push, rx_pop;
    logic en, loop_on, lb_move, spi_start, sh_busy, sh_done, dr_hit;
    logic [BITS_W-1:0] width;
    logic [4:0] status;
    logic [3:0] raw;

    assign en      = regs_q.ctrl1[C1_EN];
    assign loop_on = regs_q.ctrl1[C1_LOOP];
    assign width   = BITS_W'(regs_q.ctrl0[3:0]) + 1'b1;
    assign fmask   = ~({DATA_W{1'b1}} << width);
    assign dr_hit  = (bus_addr == OFF_DATA);

    assign tx_push   = bus_wr && dr_hit && !tx_full;
    assign rx_pop    = bus_rd && dr_hit && !rx_empty;
    assign lb_move   = en && loop_on && !tx_empty && !rx_full && !sh_busy && !sh_done;
    assign spi_start = en && !loop_on && !tx_empty && !rx_full && !sh_busy && !sh_done;
    assign tx_pop    = lb_move || spi_start;
    assign rx_push   = lb_move || sh_done;
    assign rx_din    = (lb_move ? tx_dout : sh_rx) & fmask;

    ssp_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(bus_wdata[DATA_W-1:0] & fmask),
        .pop(tx_pop), .dout(tx_dout), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

    ssp_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_din),
        .pop(rx_pop), .dout(rx_dout), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

    ssp_spi_shifter #(.DATA_W(DATA_W), .HALF(SCLK_HALF)) shifter_i (
        .clk(clk), .rst_n(rst_n), .start(spi_start), .width(width), .word(tx_dout),
        .miso(spi_miso), .busy(sh_busy), .done(sh_done), .rx_word(sh_rx),
        .sclk(spi_sclk), .csn(spi_csn), .mosi(spi_mosi));

    assign status = {(!tx_empty || sh_busy || sh_done), rx_full, !rx_empty, !tx_full, tx_empty};
    assign raw    = {(tx_cnt <= CNT_W'(THRESH)), (rx_cnt >= CNT_W'(THRESH)), 2'b00};
    assign irq    = |(raw & regs_q.mask);

    always_comb begin
        regs_d = regs_q;
        if (bus_wr) begin
            case (bus_addr)
                OFF_CTRL0: regs_d.ctrl0 = bus_wdata[15:0];
                OFF_CTRL1: regs_d.ctrl1 = bus_wdata[3:0];
                OFF_PRESC: regs_d.presc = bus_wdata[7:0];
                OFF_MASK:  regs_d.mask  = bus_wdata[3:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr[11:5] == ID_PAGE) begin
                bus_rdata = 32'(id_byte(bus_addr[4:2]));
            end else begin
                case (bus_addr)
                    OFF_CTRL0:  bus_rdata = 32'(regs_q.ctrl0);
                    OFF_CTRL1:  bus_rdata = 32'(regs_q.ctrl1);
                    OFF_DATA:   bus_rdata = rx_empty ? '0 : 32'(rx_dout);
                    OFF_STAT:   bus_rdata = 32'(status);
                    OFF_PRESC:  bus_rdata = 32'(regs_q.presc);
                    OFF_MASK:   bus_rdata = 32'(regs_q.mask);
                    OFF_RAW:    bus_rdata = 32'(raw);
                    OFF_MASKED: bus_rdata = 32'(raw & regs_q.mask);
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: tb/ssp_ctrl_tb.sv
`timescale 1ns/1ps
module ssp_ctrl_tb_top;
    localparam int HALF = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic irq, spi_sclk, spi_csn, spi_mosi;
    logic spi_miso = 1'b0;

    always #2.5 clk = ~clk;

    ssp_ctrl #(.SCLK_HALF(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .spi_sclk(spi_sclk),
        .spi_csn(spi_csn), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

    int checks = 0;
    int fails = 0;
    bit done_flag = 0;

    // reference model
    int txq[$];
    int rxq[$];
    int m_ctrl0 = 0, m_ctrl1 = 0, m_mask = 0;
    bit m_spi = 0;

    function automatic int wmask();
        return (1 << ((m_ctrl0 & 15) + 1)) - 1;
    endfunction

    function automatic int m_status();
        int s = 0;
        if (txq.size() == 0) s |= 1;
        if (txq.size() != 8) s |= 2;
        if (rxq.size() != 0) s |= 4;
        if (rxq.size() == 8) s |= 8;
        if (txq.size() != 0) s |= 16;
        return s;
    endfunction

    function automatic int m_raw();
        int r = 0;
        if (rxq.size() >= 4) r |= 4;
        if (txq.size() <= 4) r |= 8;
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            txq.delete(); rxq.delete();
            m_ctrl0 = 0; m_ctrl1 = 0; m_mask = 0;
        end else begin
            bit eng, wr_ok, rd_ok;
            int w;
            eng   = !m_spi && (m_ctrl1 & 3) == 3 && txq.size() > 0 && rxq.size() < 8;
            wr_ok = bus_wr && bus_addr == 12'h008 && txq.size() < 8;
            rd_ok = bus_rd && bus_addr == 12'h008 && rxq.size() > 0;
            w = 0;
            if (eng) w = txq.pop_front();
            if (wr_ok) txq.push_back(int'(bus_wdata[15:0]) & wmask());
            if (rd_ok) void'(rxq.pop_front());
            if (eng) rxq.push_back(w & wmask());
            if (bus_wr && bus_addr == 12'h000) m_ctrl0 = int'(bus_wdata[15:0]);
            if (bus_wr && bus_addr == 12'h004) m_ctrl1 = int'(bus_wdata[3:0]);
            if (bus_wr && bus_addr == 12'h014) m_mask  = int'(bus_wdata[3:0]);
        end
    end

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison of the interrupt line (R8)
    always @(negedge clk) begin
        if (rst_n && !done_flag)
            check(int'(irq), ((m_raw() & m_mask) != 0) ? 1 : 0, "R8 irq per clock");
    end

    // serial slave model
    int s_w = 8;
    int s_reply = 0;
    int s_cap = 0;
    int s_rises = 0;
    int s_idx = 0;
    realtime s_last = 0, s_period = 0;

    always @(negedge spi_csn) begin
        s_idx = 0; s_rises = 0; s_cap = 0;
        spi_miso = s_reply[s_w-1];
    end
    always @(posedge spi_sclk) begin
        s_cap = (s_cap << 1) | int'(spi_mosi);
        s_rises++;
        if (s_rises > 1) s_period = $realtime - s_last;
        s_last = $realtime;
    end
    always @(negedge spi_sclk) begin
        if (!spi_csn) begin
            s_idx++;
            if (s_idx < s_w) spi_miso = s_reply[s_w-1-s_idx];
        end
    end

    task automatic bus_write(input int addr, input int data);
        @(negedge clk);
        bus_addr = 12'(addr); bus_wdata = 32'(data); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int addr, output int data);
        @(negedge clk);
        bus_addr = 12'(addr); bus_rd = 1'b1;
        #1 data = int'(bus_rdata);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic read_check(input int addr, input int exp, input string tag);
        int v;
        bus_read(addr, v);
        check(v, exp, tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    task automatic spi_frame(input int wfield, input int txw, input int reply);
        int v;
        int w;
        int k;
        bus_write(12'h004, 0);
        bus_write(12'h000, wfield);
        w = wfield + 1;
        s_w = w; s_reply = reply;
        bus_write(12'h008, txw);
        bus_write(12'h004, 2);
        k = 0;
        do begin
            bus_read(12'h00C, v);
            k++;
        end while ((v & 16) != 0 && k < 500);
        void'(txq.pop_front());
        rxq.push_back(reply & wmask());
        check(s_rises, w, "R9 rising edges per frame");
        check(s_cap, txw & wmask(), "R9 mosi msb first");
        check(int'(s_period * 1000), 2 * HALF * 5000, "R9 sclk period ps");
        check(int'(spi_csn), 1, "R9 csn high after frame");
        read_check(12'h00C, m_status(), "R5 status after frame");
        read_check(12'h008, reply & wmask(), "R9 received word");
    endtask

    initial begin
        int v;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1
        read_check(12'h00C, 32'h03, "R1 status");
        read_check(12'h018, 32'h08, "R1 raw");
        read_check(12'h014, 0, "R1 mask");
        read_check(12'h01C, 0, "R1 masked");
        check(int'(irq), 0, "R1 irq");
        check(int'(spi_csn), 1, "R1 csn");
        check(int'(spi_sclk), 0, "R1 sclk");

        // R10
        bus_write(12'h000, 32'h1234_0007);
        read_check(12'h000, 32'h0007, "R10 ctrl0");
        bus_write(12'h010, 32'h1FF);
        read_check(12'h010, 32'hFF, "R10 prescale");
        bus_write(12'h004, 32'hF0);
        read_check(12'h004, 0, "R10 ctrl1 low bits");
        bus_write(12'h014, 32'h3);
        read_check(12'h014, 3, "R10 mask");
        bus_write(12'h014, 0);

        // R11
        begin
            int ids[8] = '{32'h22, 32'h10, 32'h04, 32'h00, 32'h0D, 32'hF0, 32'h05, 32'hB1};
            for (int i = 0; i < 8; i++) read_check(12'hFE0 + 4*i, ids[i], "R11 id byte");
        end

        // R12
        read_check(12'h020, 0, "R12 dma offset");
        bus_write(12'h020, 32'hFFFF);
        bus_write(12'h00C, 32'hFF);
        bus_write(12'h018, 32'hFF);
        bus_write(12'h01C, 32'hFF);
        bus_write(12'h100, 32'hFFFF);
        read_check(12'h100, 0, "R12 unmapped read");
        read_check(12'h00C, 32'h03, "R12 status unchanged");
        read_check(12'h018, 32'h08, "R12 raw unchanged");
        read_check(12'h000, 32'h07, "R12 ctrl0 unchanged");
        read_check(12'h004, 0, "R12 ctrl1 unchanged");

        // R3 R5: disabled port, fill and overfill
        for (int i = 0; i < 9; i++) bus_write(12'h008, 32'h1A0 + i);
        read_check(12'h00C, m_status(), "R5 status tx full model");
        read_check(12'h00C, 32'h10, "R5 status tx full");
        read_check(12'h018, 0, "R8 raw with tx full");
        idle(5);
        read_check(12'h008, 0, "R6 nothing moves while disabled");

        // R6 loopback
        bus_write(12'h004, 3);
        idle(12);
        read_check(12'h00C, 32'h0F, "R5 status rx full");
        read_check(12'h018, 32'h0C, "R8 raw both");
        for (int i = 0; i < 8; i++) read_check(12'h008, 32'hA0 + i, "R2 R3 masked order");
        read_check(12'h008, 0, "R4 empty read");
        read_check(12'h00C, 32'h03, "R4 status after drain");

        // R7 stall
        for (int i = 0; i < 8; i++) bus_write(12'h008, 32'h10 + i);
        idle(3);
        for (int i = 0; i < 8; i++) bus_write(12'h008, 32'h20 + i);
        idle(3);
        read_check(12'h00C, 32'h1C, "R7 stalled status");
        for (int i = 0; i < 8; i++) read_check(12'h008, 32'h10 + i, "R7 first batch");
        for (int i = 0; i < 8; i++) read_check(12'h008, 32'h20 + i, "R7 held batch");
        read_check(12'h008, 0, "R7 nothing extra");

        // R2 second cut on receive
        bus_write(12'h004, 0);
        bus_write(12'h008, 32'hFF);
        bus_write(12'h000, 3);
        bus_write(12'h004, 3);
        idle(3);
        read_check(12'h008, 32'h0F, "R2 receive cut");
        bus_write(12'h000, 7);

        // R8 interrupts
        bus_write(12'h014, 8);
        check(int'(irq), 1, "R8 tx threshold irq");
        read_check(12'h01C, 8, "R8 masked tx");
        bus_write(12'h014, 4);
        check(int'(irq), 0, "R8 rx below threshold");
        for (int i = 0; i < 4; i++) bus_write(12'h008, 32'h50 + i);
        idle(3);
        check(int'(irq), 1, "R8 rx threshold irq");
        read_check(12'h01C, 4, "R8 masked rx");
        for (int i = 0; i < 4; i++) read_check(12'h008, rxq.size() > 0 ? rxq[0] : 0, "R3 model drain");
        bus_write(12'h014, 0);

        // R9 serial frames
        m_spi = 1;
        spi_frame(11, 32'h3C7, 32'hA5C);
        spi_frame(4, 32'h15, 32'h0A);
        spi_frame(15, 32'hC3A5, 32'h5AF0);
        m_spi = 0;
        bus_write(12'h004, 0);
        read_check(12'h00C, 32'h03, "R5 idle after frames");

        idle(2);
        finish_run();
    end
endmodule